// File: doc/BRIEF.md
# Compare-Channel Interval Timer

This block is an up-counting timer peripheral. It has a selectable count source, a prescaler, three compare channels, sticky event flags and one level-sensitive interrupt line. Software reaches every register through a single-cycle, word-addressed write port and a combinational read port. The byte address is shifted right by two to form the word index.

The count source comes from one of two single-cycle tick inputs that run on the system clock: a main peripheral tick and a slow 32 kHz tick. The prescaler divides the selected ticks. In free-run mode the counter wraps at all-ones. In restart mode it returns to zero after it matches compare channel 1. A control bit requests a soft reset. The soft reset re-initialises the block but keeps the clock-select, mode and high control bits. The counter width is a parameter, with a default of 32 bits. The compare registers share that width.

Top module: `cmp_timer`

## Requirements
- R1: The word index selects the register: 0 control, 1 prescaler (its low 12 bits are kept), 2 status, 3 interrupt enable (its low 6 bits are kept), 4/5/6 compare 1/2/3 (counter width), 7/8 capture, and 9 counter. The capture registers and any unknown index read as zero. A control write stores zero in bits 2, 4 and 14:10.
- R2: Control bits 8:6 select the count source. Code 1 or 2 selects the main tick and code 4 selects the slow tick. Every other code selects nothing, so the counter does not move.
- R3: While enabled, the counter advances by one for every (prescaler+1) ticks of the selected source. The prescaler phase restarts when the timer is disabled or when the prescaler is written.
- R4: In free-run mode (control bit 9 = 1), a counted tick taken while the counter holds all-ones moves it to 0 and sets status bit 5, the rollover flag.
- R5: In restart mode (control bit 9 = 0), a counted tick taken while the counter equals compare 1 moves it to 0.
- R6: Status bits 0/1/2 are set on a counted tick taken while the counter equals compare 1/2/3. This happens whatever the interrupt-enable setting.
- R7: Status flags stay set until software writes a 1 to that bit. A write clears only the bits written as 1. Status bits 4:3 always read 0.
- R8: irq is high exactly when (status AND interrupt enable) is nonzero and control bit 0 is set.
- R9: While control bit 0 is clear, the counter holds its value. When bit 0 changes from 0 to 1 with control bit 1 set, the counter restarts from 0. With bit 1 clear, it resumes from the held value.
- R10: In restart mode, a write to compare 1 clears the counter to 0.
- R11: Hard reset sets every register to zero and every compare to all-ones. A control write with bit 15 set does the following: it clears control bits 5:0; it keeps the other control bits; it zeroes the prescaler, status, interrupt-enable and counter; it sets every compare to all-ones; and bit 15 reads back 0.
- R12: Writes to the counter index and to unknown indices change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| tick_main | input | 1 | One-cycle tick of the main peripheral count source |
| tick_slow | input | 1 | One-cycle tick of the 32 kHz count source |
| reg_addr | input | BADDR_W | Byte address; bits above 1 form the word index |
| reg_wr | input | 1 | Write strobe, one write per cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq | output | 1 | Level interrupt |

## Verification
The bench uses an 8-bit counter so that rollover can be reached.

The bench applies the following stimulus patterns:
- **Count-source sweep:** all eight source codes, each fed a mix of main and slow ticks. The resulting count separates the codes that count main ticks, the code that counts slow ticks, and the dead codes.
- **Prescaler sweep:** several prescaler values, each with a fixed number of ticks. The resulting count shows whether the divide ratio is off by one.
- **Long free-run pass:** walks the counter through all three compare values and the wrap. This separates a flag that is raised on the matching tick from one raised a tick late.
- **Restart-mode pass:** separates a counter cleared on a match from one that only wraps.
- **Interrupt gating:** each flag is combined with different enable masks and with the enable bit toggled.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   // word indices of the register map
   localparam logic [3:0] IDX_CTRL = 4'd0;
   localparam logic [3:0] IDX_PRE  = 4'd1;
   localparam logic [3:0] IDX_STAT = 4'd2;
   localparam logic [3:0] IDX_IEN  = 4'd3;
   localparam logic [3:0] IDX_CMP1 = 4'd4;
   localparam logic [3:0] IDX_CMP2 = 4'd5;
   localparam logic [3:0] IDX_CMP3 = 4'd6;
   localparam logic [3:0] IDX_CAP1 = 4'd7;
   localparam logic [3:0] IDX_CAP2 = 4'd8;
   localparam logic [3:0] IDX_CNT  = 4'd9;

   // control bit positions
   localparam int CB_EN     = 0;
   localparam int CB_ENMODE = 1;
   localparam int CB_SEL_LO = 6;
   localparam int CB_FREE   = 9;
   localparam int CB_SWR    = 15;

   // bits stored as zero on every control write
   localparam logic [31:0] CTRL_ZERO_MASK = 32'h0000_7C14;
   // bits cleared by a soft reset (low enables and the reset request itself)
   localparam logic [31:0] CTRL_SOFT_MASK = 32'h0000_803F;

   localparam int FLAG_W  = 6;
   localparam int FB_ROLL = 5;
   localparam int NCMP    = 3;

   typedef enum logic [2:0] {
      SRC_OFF0  = 3'd0,
      SRC_MAIN  = 3'd1,
      SRC_MAINH = 3'd2,
      SRC_SLOW  = 3'd4
   } src_sel_e;

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
   parameter int PRE_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic             clr_i,
   input  logic             src_i,
   input  logic [PRE_W-1:0] div_i,
   output logic             tick_o
);

   logic [PRE_W-1:0] phase_q;
   logic             last_w;

   assign last_w = (phase_q == div_i);
   assign tick_o = en_i & src_i & last_w;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
      end else if (clr_i || !en_i) begin
         phase_q <= '0;
      end else if (src_i) begin
         phase_q <= last_w ? '0 : phase_q + 1'b1;
      end
   end

   // a divided tick always starts a fresh phase (R3)
   assert_phase_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |=> (phase_q == '0));

   // no phase advance while disabled (R9)
   assert_phase_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> (phase_q == '0));

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             free_i,
   input  logic             clr_i,
   input  logic [CNT_W-1:0] limit_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             wrap_o
);

   logic [CNT_W-1:0] cnt_q;
   logic             hit_w;

   assign hit_w  = !free_i && (cnt_q == limit_i);
   assign wrap_o = tick_i && (cnt_q == '1);
   assign cnt_o  = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr_i) begin
         cnt_q <= '0;
      end else if (tick_i) begin
         cnt_q <= hit_w ? '0 : cnt_q + 1'b1;
      end
   end

   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !clr_i) |=> $stable(cnt_q));

   assert_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !free_i && (cnt_q == limit_i)) |=> (cnt_q == '0));

   assert_free_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && free_i && !clr_i) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

endmodule

// File: rtl/tmr_status.sv
module tmr_status #(
   parameter int FW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [FW-1:0] set_i,
   input  logic [FW-1:0] w1c_i,
   input  logic          clr_all_i,
   output logic [FW-1:0] flags_o
);

   logic [FW-1:0] flags_q;

   assign flags_o = flags_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q <= '0;
      end else if (clr_all_i) begin
         flags_q <= '0;
      end else begin
         flags_q <= (flags_q & ~w1c_i) | set_i;
      end
   end

   // flags are sticky unless software writes ones (R7)
   assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_all_i && (w1c_i == '0)) |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

   // a set event is visible next cycle (R6)
   assert_set_seen_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_all_i && (set_i != '0)) |=> ((flags_q & $past(set_i)) == $past(set_i)));

endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
   import tmr_pkg::*;
#(
   parameter int CNT_W   = 32,
   parameter int PRE_W   = 12,
   parameter int BADDR_W = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick_main,
   input  logic               tick_slow,
   input  logic [BADDR_W-1:0] reg_addr,
   input  logic               reg_wr,
   input  logic [31:0]        reg_wdata,
   output logic [31:0]        reg_rdata,
   output logic               irq
);

   localparam int WORD_W = BADDR_W - 2;

   // elaboration-time parameter checks
   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt_w
      $error("cmp_timer: CNT_W must lie in 2..32");
   end
   if (PRE_W < 1 || PRE_W > 16) begin : g_bad_pre_w
      $error("cmp_timer: PRE_W must lie in 1..16");
   end
   if (BADDR_W < 6) begin : g_bad_addr_w
      $error("cmp_timer: BADDR_W must be at least 6");
   end

   logic [WORD_W-1:0] word;
   logic              in_map;
   logic [15:0]       wsel;

   assign word   = reg_addr[BADDR_W-1:2];
   assign in_map = ((word >> 4) == '0);

   always_comb begin
      wsel = '0;
      if (reg_wr && in_map) wsel[word[3:0]] = 1'b1;
   end

   // ---------------- control, prescaler, enable registers
   logic [31:0]       ctrl_q;
   logic [PRE_W-1:0]  pre_q;
   logic [FLAG_W-1:0] ien_q;
   logic              soft_rst;
   logic [31:0]       ctrl_wval;

   assign soft_rst  = wsel[IDX_CTRL] && reg_wdata[CB_SWR];
   assign ctrl_wval = reg_wdata & ~CTRL_ZERO_MASK;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wsel[IDX_CTRL]) begin
         ctrl_q <= soft_rst ? (ctrl_wval & ~CTRL_SOFT_MASK) : ctrl_wval;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q <= '0;
         ien_q <= '0;
      end else if (soft_rst) begin
         pre_q <= '0;
         ien_q <= '0;
      end else begin
         if (wsel[IDX_PRE]) pre_q <= reg_wdata[PRE_W-1:0];
         if (wsel[IDX_IEN]) ien_q <= reg_wdata[FLAG_W-1:0];
      end
   end

   logic en, free_run;
   assign en       = ctrl_q[CB_EN];
   assign free_run = ctrl_q[CB_FREE];

   // ---------------- count source selection
   logic src_tick;
   always_comb begin
      unique case (src_sel_e'(ctrl_q[CB_SEL_LO +: 3]))
         SRC_MAIN, SRC_MAINH: src_tick = tick_main;
         SRC_SLOW:            src_tick = tick_slow;
         default:             src_tick = 1'b0;
      endcase
   end

   logic cnt_tick;
   tmr_prescale #(.PRE_W(PRE_W)) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (en),
      .clr_i  (soft_rst | wsel[IDX_PRE]),
      .src_i  (src_tick),
      .div_i  (pre_q),
      .tick_o (cnt_tick)
   );

   // ---------------- compare channels
   logic [CNT_W-1:0] cmp_q [NCMP];
   logic [NCMP-1:0]  match;
   logic [CNT_W-1:0] cnt;

   for (genvar k = 0; k < NCMP; k++) begin : g_cmp
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cmp_q[k] <= '1;
         end else if (soft_rst) begin
            cmp_q[k] <= '1;
         end else if (wsel[int'(IDX_CMP1) + k]) begin
            cmp_q[k] <= reg_wdata[CNT_W-1:0];
         end
      end
      assign match[k] = cnt_tick && (cnt == cmp_q[k]);
   end

   // ---------------- counter
   logic cnt_clr, en_rise_clr, wrap;
   assign en_rise_clr = wsel[IDX_CTRL] && !reg_wdata[CB_SWR] && !en &&
                        reg_wdata[CB_EN] && reg_wdata[CB_ENMODE];
   assign cnt_clr = soft_rst || en_rise_clr || (wsel[IDX_CMP1] && !free_run);

   tmr_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_i  (cnt_tick),
      .free_i  (free_run),
      .clr_i   (cnt_clr),
      .limit_i (cmp_q[0]),
      .cnt_o   (cnt),
      .wrap_o  (wrap)
   );

   // ---------------- status flags
   logic [FLAG_W-1:0] stat, stat_set, stat_w1c;
   assign stat_set = {wrap, 2'b00, match};
   assign stat_w1c = wsel[IDX_STAT] ? reg_wdata[FLAG_W-1:0] : '0;

   tmr_status #(.FW(FLAG_W)) u_stat (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (stat_set),
      .w1c_i     (stat_w1c),
      .clr_all_i (soft_rst),
      .flags_o   (stat)
   );

   assign irq = en && ((stat & ien_q) != '0);

   // ---------------- read port
   always_comb begin
      reg_rdata = '0;
      if (in_map) begin
         case (word[3:0])
            IDX_CTRL: reg_rdata = ctrl_q;
            IDX_PRE:  reg_rdata = 32'(pre_q);
            IDX_STAT: reg_rdata = 32'(stat);
            IDX_IEN:  reg_rdata = 32'(ien_q);
            IDX_CMP1: reg_rdata = 32'(cmp_q[0]);
            IDX_CMP2: reg_rdata = 32'(cmp_q[1]);
            IDX_CMP3: reg_rdata = 32'(cmp_q[2]);
            IDX_CNT:  reg_rdata = 32'(cnt);
            default:  reg_rdata = '0;
         endcase
      end
   end

   // ---------------- assertions
   assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_q[CB_EN] |-> !irq);

   assert_rsvd_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
      stat[4:3] == 2'b00);

   assert_soft_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (!ctrl_q[CB_SWR] && !ctrl_q[CB_EN] && (pre_q == '0) &&
                    (cnt == '0) && (cmp_q[0] == '1)));

   assert_ctrl_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q & CTRL_ZERO_MASK) == '0);

   assert_no_move_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!src_tick && !cnt_clr) |=> $stable(cnt));

endmodule

// File: tb/tb_cmp_timer.sv
`timescale 1ns/1ps
module tb_cmp_timer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_main = 1'b0;
   logic        tick_slow = 1'b0;
   logic [5:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq;

   int errs = 0;
   int checks = 0;
   int cycles = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   cmp_timer #(.CNT_W(8), .PRE_W(12), .BADDR_W(6)) dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_main (tick_main),
      .tick_slow (tick_slow),
      .reg_addr  (reg_addr),
      .reg_wr    (reg_wr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .irq       (irq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input int idx, input logic [31:0] d);
      @(negedge clk);
      reg_addr  = 6'(idx * 4);
      reg_wdata = d;
      reg_wr    = 1'b1;
      @(negedge clk);
      reg_wr    = 1'b0;
   endtask

   task automatic rd(input int idx, output logic [31:0] d);
      reg_addr = 6'(idx * 4);
      #1 d = reg_rdata;
   endtask

   task automatic rchk(input string tag, input int idx, input logic [31:0] exp);
      logic [31:0] v;
      rd(idx, v);
      chk(tag, v, exp);
   endtask

   task automatic pulse(input bit slow, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (slow) tick_slow = 1'b1; else tick_main = 1'b1;
         @(negedge clk);
         tick_main = 1'b0;
         tick_slow = 1'b0;
      end
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !done) begin
         done = 1'b1;
         checks++;
         errs++;
         $display("FAIL watchdog (all requirements) act=timeout exp=completion");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R11: hard reset state
      rchk("R11 reset ctrl", 0, 32'h0);
      rchk("R11 reset pre", 1, 32'h0);
      rchk("R11 reset stat", 2, 32'h0);
      rchk("R11 reset ien", 3, 32'h0);
      rchk("R11 reset cmp1", 4, 32'hFF);
      rchk("R11 reset cmp2", 5, 32'hFF);
      rchk("R11 reset cmp3", 6, 32'hFF);
      rchk("R11 reset cnt", 9, 32'h0);
      chk("R8 reset irq", 32'(irq), 32'h0);

      // R1: field masks and read-as-zero locations
      wr(1, 32'hFFFF_FFFF);
      rchk("R1 pre mask", 1, 32'hFFF);
      wr(3, 32'hFFFF_FFFF);
      rchk("R1 ien mask", 3, 32'h3F);
      wr(0, 32'h0000_7E14);
      rchk("R1 ctrl forced zeros", 0, 32'h200);
      wr(5, 32'h1234);
      rchk("R1 cmp2 width", 5, 32'h34);
      rchk("R1 capture1 zero", 7, 32'h0);
      rchk("R1 capture2 zero", 8, 32'h0);
      rchk("R1 unknown zero", 12, 32'h0);
      wr(1, 0);
      wr(3, 0);
      wr(5, 32'hFF);

      // R2: source select sweep
      for (int s = 0; s < 8; s++) begin
         logic [31:0] e;
         wr(0, 32'h200 | (s << 6));
         wr(0, 32'h203 | (s << 6));
         pulse(0, 3);
         pulse(1, 2);
         e = (s == 1 || s == 2) ? 32'd3 : (s == 4) ? 32'd2 : 32'd0;
         rchk($sformatf("R2 source code %0d", s), 9, e);
      end

      // R3: prescaler sweep
      begin
         int plist [5] = '{0, 1, 2, 3, 6};
         for (int i = 0; i < 5; i++) begin
            wr(1, plist[i]);
            wr(0, 32'h240);
            wr(0, 32'h243);
            pulse(0, 14);
            rchk($sformatf("R3 prescale %0d", plist[i]), 9, 32'(14 / (plist[i] + 1)));
         end
      end
      wr(1, 0);

      // free-run pass: R6 R7 R8 R9 R4
      wr(0, 32'h240);
      wr(4, 5);
      wr(5, 9);
      wr(6, 200);
      wr(0, 32'h243);
      pulse(0, 5);
      rchk("R6 count before match", 9, 32'd5);
      rchk("R6 no flag before match tick", 2, 32'h0);
      pulse(0, 1);
      rchk("R6 flag cmp1", 2, 32'h1);
      chk("R8 irq masked", 32'(irq), 32'h0);
      wr(3, 1);
      chk("R8 irq enabled", 32'(irq), 32'h1);
      wr(2, 1);
      rchk("R7 w1c clears", 2, 32'h0);
      chk("R8 irq after clear", 32'(irq), 32'h0);
      pulse(0, 4);
      rchk("R6 flag cmp2", 2, 32'h2);
      wr(0, 32'h240);
      pulse(0, 3);
      rchk("R9 hold while disabled", 9, 32'd10);
      wr(0, 32'h241);
      rchk("R9 resume without enable mode", 9, 32'd10);
      pulse(0, 245);
      rchk("R4 count at all-ones", 9, 32'd255);
      rchk("R6 flags cmp2 and cmp3", 2, 32'h6);
      wr(2, 2);
      rchk("R7 partial w1c", 2, 32'h4);
      wr(3, 32'h20);
      wr(2, 32'h3F);
      rchk("R7 clear all", 2, 32'h0);
      pulse(0, 1);
      rchk("R4 wrap to zero", 9, 32'd0);
      rchk("R4 rollover flag", 2, 32'h20);
      chk("R8 irq on rollover", 32'(irq), 32'h1);
      wr(0, 32'h240);
      chk("R8 irq gated by enable", 32'(irq), 32'h0);
      wr(0, 32'h241);
      chk("R8 irq back with enable", 32'(irq), 32'h1);
      wr(2, 32'h20);
      wr(3, 0);

      // restart pass: R5 R10 R12 R9
      wr(0, 32'h240);
      wr(0, 32'h043);
      wr(4, 5);
      pulse(0, 6);
      rchk("R5 restart after cmp1", 9, 32'd0);
      rchk("R5 cmp1 flag", 2, 32'h1);
      pulse(0, 2);
      rchk("R5 counting after restart", 9, 32'd2);
      wr(4, 7);
      rchk("R10 cmp1 write clears", 9, 32'd0);
      pulse(0, 3);
      wr(9, 32'h55);
      rchk("R12 counter write ignored", 9, 32'd3);
      wr(13, 32'hFFFF_FFFF);
      rchk("R12 unknown write ctrl", 0, 32'h43);
      rchk("R12 unknown write pre", 1, 32'h0);
      rchk("R12 unknown write cmp1", 4, 32'h7);
      wr(0, 32'h042);
      wr(0, 32'h043);
      rchk("R9 enable mode restarts", 9, 32'd0);
      wr(2, 32'h3F);

      // R11: soft reset keeps the upper control bits
      wr(1, 3);
      wr(3, 32'h21);
      wr(5, 32'h44);
      wr(0, 32'h00FF_0243);
      pulse(0, 8);
      rchk("R11 pre-reset count", 9, 32'd2);
      wr(0, 32'h00FF_8243);
      rchk("R11 soft ctrl", 0, 32'h00FF_0240);
      rchk("R11 soft pre", 1, 32'h0);
      rchk("R11 soft stat", 2, 32'h0);
      rchk("R11 soft ien", 3, 32'h0);
      rchk("R11 soft cmp1", 4, 32'hFF);
      rchk("R11 soft cmp2", 5, 32'hFF);
      rchk("R11 soft cmp3", 6, 32'hFF);
      rchk("R11 soft cnt", 9, 32'h0);
      pulse(0, 3);
      rchk("R11 stopped after soft reset", 9, 32'h0);

      done = 1'b1;
      finish_run();
   end

endmodule